// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox Unit

This block lets processor cores signal one another through memory-mapped registers. Every core owns a register window with two independent interrupt groups (each a pending-status word, an enable word, a write-one-to-set strobe and a write-one-to-clear strobe) plus a mailbox of four 64-bit words. Any core may post message bits into another core's pending status and may leave data, such as start arguments, in that core's mailbox. The block drives one interrupt line per core.

Several requesters reach the block at once, each through its own simple register port: address, write flag, access width (32 or 64 bits), write data, read data and a ready flag that answers every request one cycle later. Posts from different ports in the same cycle are merged. A typical boot sequence writes the spare, global-pointer and stack words of a target core's mailbox first and the start-address word last. The waiting core polls word 0 until it reads a nonzero value, and writes it back to zero once it runs.

The address is a byte address: bits above bit 7 pick the core, so core windows are 0x100 apart. Reset is asynchronous active-low and is released inside the block through a two-stage synchroniser.

Top module: `ipi_mbox_unit`

## Requirements
- R1: After reset every status, enable and mailbox word is zero, every interrupt line is low and no port shows ready.
- R2: Writing a 32-bit value to the set strobe (offset 0x08 for group 0, 0x18 for group 1) makes each status bit written as 1 pending, and bits written as 0 keep their state.
- R3: Writing to the clear strobe (offset 0x0C for group 0, 0x1C for group 1) removes each pending bit written as 1, and the other bits keep their state.
- R4: When one cycle carries a set and a clear of the same bit for the same core, from different ports, that bit ends up pending.
- R5: A core's interrupt line is high exactly while some status bit of either group has its matching enable bit set (enable at 0x04 for group 0, 0x14 for group 1).
- R6: Reading the set or clear strobes returns zero. Status (0x00, 0x10) and enable words return their current contents in read data bits 31:0, with bits 63:32 zero.
- R7: The mailbox holds four 64-bit words at offsets 0x20, 0x28, 0x30 and 0x38. A 64-bit access, which needs address bit 2 clear, writes or reads the whole word.
- R8: A 32-bit access to a mailbox word addresses its low half when address bit 2 is 0 and its high half when it is 1, using write data bits 31:0. A half write leaves the other half unchanged, and a half read returns the half in bits 31:0.
- R9: Each core's registers sit at core index times 0x100, and an access to one core changes neither the registers nor the interrupt line of another.
- R10: ready is high in the cycle after each cycle with valid high and low otherwise; read data is valid while ready is high.
- R11: Set bits posted by several ports in one cycle to the same core are ORed. When several ports write the same enable word or mailbox half in one cycle, the highest-numbered port's data is kept.
- R12: Writes to a status word, to offsets 0x40 to 0xFF, with address bits 1:0 nonzero, with 64-bit width outside the mailbox, or with 64-bit width and address bit 2 set change nothing, and such reads return zero.
- R13: The two interrupt groups of a core are independent: posting, enabling or clearing in one leaves the other group's status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | NUM_PORTS | Request present, one bit per port |
| bus_write | input | NUM_PORTS | 1 = write, 0 = read, per port |
| bus_sz64 | input | NUM_PORTS | 1 = 64-bit access, 0 = 32-bit access, per port |
| bus_addr | input | NUM_PORTS x ADDR_W | Byte address per port (core index above bit 7) |
| bus_wdata | input | NUM_PORTS x 64 | Write data per port |
| bus_ready | output | NUM_PORTS | Request answered, one cycle after valid |
| bus_rdata | output | NUM_PORTS x 64 | Read data, valid with ready |
| irq | output | NUM_CORES | Interrupt line per core |

## Verification
The functions that can meet in one cycle are a post through the set strobe and a removal through the clear strobe aimed at the same core and bit, coming from two different ports. The bench provokes this by driving both ports in the same cycle, one setting a bit that the other clears while also clearing a second bit that was already pending, and it judges the result by reading the status word back: the contested bit must be pending and the other cleared bit gone. The same dual-port drive also checks set merging and highest-port-wins on enable and mailbox writes.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;

  localparam int LOCAL_W    = 8;  // byte offset bits inside one core window
  localparam int MBOX_WORDS = 4;
  localparam int WORD_IDX_W = $clog2(MBOX_WORDS);

  typedef enum logic [3:0] {
    K_NONE,
    K_STAT0,
    K_EN0,
    K_SET0,
    K_CLR0,
    K_STAT1,
    K_EN1,
    K_SET1,
    K_CLR1,
    K_MBOX
  } reg_kind_e;

  // write side of one decoded request
  typedef struct packed {
    logic                  wr;
    reg_kind_e             kind;
    logic [WORD_IDX_W-1:0] word;
    logic                  lo_en;
    logic                  hi_en;
    logic [63:0]           data;
  } wr_req_t;

  // read side of one decoded request
  typedef struct packed {
    logic                  rd;
    reg_kind_e             kind;
    logic [WORD_IDX_W-1:0] word;
    logic                  half;
    logic                  full;
  } rd_sel_t;

endpackage

// File: rtl/ipi_mbox_decode.sv
module ipi_mbox_decode
  import ipi_mbox_pkg::*;
#(
  parameter  int NUM_CORES = 4,
  parameter  int CORE_W    = 2,
  localparam int ADDR_W    = CORE_W + LOCAL_W
) (
  input  logic                 valid,
  input  logic                 write,
  input  logic                 sz64,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [63:0]          wdata,
  output wr_req_t              wreq,
  output rd_sel_t              rsel,
  output logic [CORE_W-1:0]    core_idx,
  output logic [NUM_CORES-1:0] core_hit
);

  logic [LOCAL_W-1:0] off;
  logic               in_range;
  reg_kind_e          kind;
  logic               lo_en;
  logic               hi_en;

  always_comb begin
    off      = addr[LOCAL_W-1:0];
    core_idx = addr[ADDR_W-1:LOCAL_W];
    in_range = ({1'b0, core_idx} < (CORE_W+1)'(NUM_CORES));
    kind     = K_NONE;
    lo_en    = 1'b0;
    hi_en    = 1'b0;
    if (in_range && (off[7:6] == 2'b00) && (off[1:0] == 2'b00)) begin
      if (off[5]) begin
        if (sz64) begin
          if (!off[2]) begin
            kind  = K_MBOX;
            lo_en = 1'b1;
            hi_en = 1'b1;
          end
        end else begin
          kind  = K_MBOX;
          lo_en = !off[2];
          hi_en = off[2];
        end
      end else if (!sz64) begin
        case (off[4:2])
          3'd0: kind = K_STAT0;
          3'd1: kind = K_EN0;
          3'd2: kind = K_SET0;
          3'd3: kind = K_CLR0;
          3'd4: kind = K_STAT1;
          3'd5: kind = K_EN1;
          3'd6: kind = K_SET1;
          3'd7: kind = K_CLR1;
          default: kind = K_NONE;
        endcase
      end
    end
  end

  always_comb begin
    wreq.wr    = valid & write;
    wreq.kind  = kind;
    wreq.word  = off[4:3];
    wreq.lo_en = lo_en;
    wreq.hi_en = hi_en;
    wreq.data  = sz64 ? wdata : {wdata[31:0], wdata[31:0]};
    rsel.rd    = valid & ~write;
    rsel.kind  = kind;
    rsel.word  = off[4:3];
    rsel.half  = off[2];
    rsel.full  = sz64;
  end

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      core_hit[c] = in_range && (core_idx == CORE_W'(c));
    end
  end

endmodule

// File: rtl/ipi_mbox_core.sv
module ipi_mbox_core
  import ipi_mbox_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  wr_req_t [NUM_PORTS-1:0]          wreq,
  input  logic    [NUM_PORTS-1:0]          hit,
  output logic    [31:0]                   st0_q,
  output logic    [31:0]                   en0_q,
  output logic    [31:0]                   st1_q,
  output logic    [31:0]                   en1_q,
  output logic    [MBOX_WORDS-1:0][63:0]   mbox_q,
  output logic                             irq
);

  logic [31:0]                 set0, clr0, set1, clr1;
  logic [31:0]                 st0_n, st1_n, en0_n, en1_n;
  logic                        st0_ce, st1_ce, en0_ce, en1_ce;
  logic [MBOX_WORDS-1:0][63:0] mbox_n;
  logic [MBOX_WORDS-1:0]       mbox_ce;

  // next-state: ports scanned upward so a higher port overrides a lower one
  always_comb begin
    set0    = '0;
    clr0    = '0;
    set1    = '0;
    clr1    = '0;
    en0_n   = en0_q;
    en1_n   = en1_q;
    en0_ce  = 1'b0;
    en1_ce  = 1'b0;
    mbox_n  = mbox_q;
    mbox_ce = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (hit[p] && wreq[p].wr) begin
        case (wreq[p].kind)
          K_SET0: set0 = set0 | wreq[p].data[31:0];
          K_CLR0: clr0 = clr0 | wreq[p].data[31:0];
          K_SET1: set1 = set1 | wreq[p].data[31:0];
          K_CLR1: clr1 = clr1 | wreq[p].data[31:0];
          K_EN0: begin
            en0_n  = wreq[p].data[31:0];
            en0_ce = 1'b1;
          end
          K_EN1: begin
            en1_n  = wreq[p].data[31:0];
            en1_ce = 1'b1;
          end
          K_MBOX: begin
            if (wreq[p].lo_en) begin
              mbox_n[wreq[p].word][31:0] = wreq[p].data[31:0];
            end
            if (wreq[p].hi_en) begin
              mbox_n[wreq[p].word][63:32] = wreq[p].data[63:32];
            end
            mbox_ce[wreq[p].word] = 1'b1;
          end
          default: ;
        endcase
      end
    end
    // a post wins over a removal of the same bit
    st0_n  = (st0_q & ~clr0) | set0;
    st1_n  = (st1_q & ~clr1) | set1;
    st0_ce = |(set0 | clr0);
    st1_ce = |(set1 | clr1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st0_q <= '0;
      st1_q <= '0;
      en0_q <= '0;
      en1_q <= '0;
    end else begin
      if (st0_ce) st0_q <= st0_n;
      if (st1_ce) st1_q <= st1_n;
      if (en0_ce) en0_q <= en0_n;
      if (en1_ce) en1_q <= en1_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mbox_q <= '0;
    end else begin
      for (int w = 0; w < MBOX_WORDS; w++) begin
        if (mbox_ce[w]) mbox_q[w] <= mbox_n[w];
      end
    end
  end

  assign irq = (|(st0_q & en0_q)) || (|(st1_q & en1_q));

  assert_set_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set0 != '0) |=> ((st0_q & $past(set0)) == $past(set0)));

  assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr1 & ~set1) != '0) |=> ((st1_q & $past(clr1 & ~set1)) == '0));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((set0 & clr0) != '0) |=> ((st0_q & $past(set0 & clr0)) == $past(set0 & clr0)));

  assert_no_enable_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((en0_q == '0) && (en1_q == '0)) |-> !irq);

  assert_group_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((set1 == '0) && (clr1 == '0)) |=> $stable(st1_q));

  assert_mbox_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_ce == '0) |=> $stable(mbox_q));

endmodule

// File: rtl/ipi_mbox_rdmux.sv
module ipi_mbox_rdmux
  import ipi_mbox_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2
) (
  input  rd_sel_t                                     sel,
  input  logic [CORE_W-1:0]                           core_idx,
  input  logic [NUM_CORES-1:0][31:0]                  st0,
  input  logic [NUM_CORES-1:0][31:0]                  en0,
  input  logic [NUM_CORES-1:0][31:0]                  st1,
  input  logic [NUM_CORES-1:0][31:0]                  en1,
  input  logic [NUM_CORES-1:0][MBOX_WORDS-1:0][63:0]  mbox,
  output logic [63:0]                                 rdata
);

  logic [63:0] word;

  always_comb begin
    word  = mbox[core_idx][sel.word];
    rdata = '0;
    if (sel.rd) begin
      case (sel.kind)
        K_STAT0: rdata = {32'b0, st0[core_idx]};
        K_EN0:   rdata = {32'b0, en0[core_idx]};
        K_STAT1: rdata = {32'b0, st1[core_idx]};
        K_EN1:   rdata = {32'b0, en1[core_idx]};
        K_MBOX:  rdata = sel.full ? word
                                  : {32'b0, (sel.half ? word[63:32] : word[31:0])};
        default: rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/ipi_mbox_unit.sv
module ipi_mbox_unit
  import ipi_mbox_pkg::*;
#(
  parameter  int NUM_CORES = 4,
  parameter  int NUM_PORTS = 2,
  localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int ADDR_W    = CORE_W + LOCAL_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PORTS-1:0]              bus_valid,
  input  logic [NUM_PORTS-1:0]              bus_write,
  input  logic [NUM_PORTS-1:0]              bus_sz64,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  bus_addr,
  input  logic [NUM_PORTS-1:0][63:0]        bus_wdata,
  output logic [NUM_PORTS-1:0]              bus_ready,
  output logic [NUM_PORTS-1:0][63:0]        bus_rdata,
  output logic [NUM_CORES-1:0]              irq
);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wr_req_t [NUM_PORTS-1:0]                    wreqs;
  rd_sel_t [NUM_PORTS-1:0]                    rsels;
  logic    [NUM_PORTS-1:0][CORE_W-1:0]        core_idx;
  logic    [NUM_PORTS-1:0][NUM_CORES-1:0]     port_hit;
  logic    [NUM_CORES-1:0][NUM_PORTS-1:0]     core_hits;
  logic    [NUM_PORTS-1:0][63:0]              rdata_n;

  logic [NUM_CORES-1:0][31:0]                 st0_a, en0_a, st1_a, en1_a;
  logic [NUM_CORES-1:0][MBOX_WORDS-1:0][63:0] mbox_a;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    ipi_mbox_decode #(
      .NUM_CORES(NUM_CORES),
      .CORE_W   (CORE_W)
    ) u_dec (
      .valid   (bus_valid[p]),
      .write   (bus_write[p]),
      .sz64    (bus_sz64[p]),
      .addr    (bus_addr[p]),
      .wdata   (bus_wdata[p]),
      .wreq    (wreqs[p]),
      .rsel    (rsels[p]),
      .core_idx(core_idx[p]),
      .core_hit(port_hit[p])
    );

    ipi_mbox_rdmux #(
      .NUM_CORES(NUM_CORES),
      .CORE_W   (CORE_W)
    ) u_rdmux (
      .sel     (rsels[p]),
      .core_idx(core_idx[p]),
      .st0     (st0_a),
      .en0     (en0_a),
      .st1     (st1_a),
      .en1     (en1_a),
      .mbox    (mbox_a),
      .rdata   (rdata_n[p])
    );

    assert_ready_follows_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
      bus_valid[p] |=> bus_ready[p]);

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
      !bus_valid[p] |=> !bus_ready[p]);
  end

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        core_hits[c][p] = port_hit[p][c];
      end
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    ipi_mbox_core #(
      .NUM_PORTS(NUM_PORTS)
    ) u_core (
      .clk   (clk),
      .rst_n (rst_int_n),
      .wreq  (wreqs),
      .hit   (core_hits[c]),
      .st0_q (st0_a[c]),
      .en0_q (en0_a[c]),
      .st1_q (st1_a[c]),
      .en1_q (en1_a[c]),
      .mbox_q(mbox_a[c]),
      .irq   (irq[c])
    );
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bus_ready <= '0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_valid;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (bus_valid[p]) bus_rdata[p] <= rdata_n[p];
      end
    end
  end

endmodule

// File: tb/ipi_mbox_unit_tb_top.sv
module ipi_mbox_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NP = 2;
  localparam int AW = 10;

  logic                  clk;
  logic                  rst_n;
  logic [NP-1:0]         vld, wr, sz;
  logic [NP-1:0][AW-1:0] addr;
  logic [NP-1:0][63:0]   wdata;
  logic [NP-1:0]         rdy;
  logic [NP-1:0][63:0]   rdata;
  logic [NC-1:0]         irq;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  ipi_mbox_unit #(.NUM_CORES(NC), .NUM_PORTS(NP)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(vld),
    .bus_write(wr),
    .bus_sz64 (sz),
    .bus_addr (addr),
    .bus_wdata(wdata),
    .bus_ready(rdy),
    .bus_rdata(rdata),
    .irq      (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] ad(int core, int off);
    return {2'(core), 8'(off)};
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic idle_all();
    vld = '0; wr = '0; sz = '0; addr = '0; wdata = '0;
  endtask

  // all tasks start and end at a falling edge
  task automatic wr1(int p, logic [AW-1:0] a, logic [63:0] d, bit s64);
    vld[p] = 1'b1; wr[p] = 1'b1; sz[p] = s64; addr[p] = a; wdata[p] = d;
    @(negedge clk);
    idle_all();
  endtask

  task automatic wr2(logic [AW-1:0] a0, logic [63:0] d0, logic [AW-1:0] a1,
                     logic [63:0] d1, bit s64);
    vld = 2'b11; wr = 2'b11; sz = {s64, s64};
    addr[0] = a0; wdata[0] = d0; addr[1] = a1; wdata[1] = d1;
    @(negedge clk);
    idle_all();
  endtask

  task automatic rd1(int p, logic [AW-1:0] a, bit s64, output logic [63:0] d,
                     output logic r);
    vld[p] = 1'b1; wr[p] = 1'b0; sz[p] = s64; addr[p] = a;
    @(negedge clk);
    d = rdata[p];
    r = rdy[p];
    idle_all();
  endtask

  function automatic logic [63:0] mword(int c, int w);
    return {32'h1000_0000 + 32'(c*16 + w), 32'hC0DE_0000 + 32'(c*16 + w)};
  endfunction

  task automatic t_reset();
    logic [63:0] d; logic r;
    chk("R1 irq after reset", 64'(irq), 64'h0);
    chk("R1 ready idle after reset", 64'(rdy), 64'h0);
    rd1(0, ad(0, 8'h00), 0, d, r); chk("R1 status0 core0", d, 0);
    rd1(1, ad(1, 8'h04), 0, d, r); chk("R1 enable0 core1", d, 0);
    rd1(0, ad(3, 8'h10), 0, d, r); chk("R1 status1 core3", d, 0);
    rd1(1, ad(2, 8'h38), 1, d, r); chk("R1 mailbox core2 word3", d, 0);
  endtask

  task automatic t_set();
    logic [63:0] d; logic r;
    wr1(0, ad(1, 8'h08), 64'h5, 0);
    wr1(0, ad(1, 8'h08), 64'h2, 0);
    rd1(0, ad(1, 8'h00), 0, d, r); chk("R2 set ORs into status", d, 64'h7);
    rd1(0, ad(1, 8'h08), 0, d, r); chk("R6 set strobe reads zero", d, 0);
    rd1(1, ad(1, 8'h0C), 0, d, r); chk("R6 clear strobe reads zero", d, 0);
    chk("R5 irq low while disabled", 64'(irq[1]), 0);
  endtask

  task automatic t_clear_irq();
    logic [63:0] d; logic r;
    wr1(1, ad(1, 8'h04), 64'h2, 0);
    chk("R5 irq high when enabled bit pending", 64'(irq[1]), 1);
    rd1(0, ad(1, 8'h04), 0, d, r); chk("R6 enable reads back", d, 64'h2);
    wr1(0, ad(1, 8'h0C), 64'h3, 0);
    rd1(0, ad(1, 8'h00), 0, d, r); chk("R3 clear removes written ones only", d, 64'h4);
    chk("R5 irq low after clear", 64'(irq[1]), 0);
  endtask

  task automatic t_group1();
    logic [63:0] d; logic r;
    wr1(0, ad(2, 8'h18), 64'h8000_0000, 0);
    chk("R5 irq low, group1 disabled", 64'(irq[2]), 0);
    wr1(1, ad(2, 8'h14), 64'h8000_0000, 0);
    chk("R13 group1 raises irq", 64'(irq[2]), 1);
    chk("R9 other cores quiet", 64'({irq[3], irq[0]}), 0);
    rd1(0, ad(2, 8'h00), 0, d, r); chk("R13 group0 untouched", d, 0);
    rd1(0, ad(2, 8'h10), 0, d, r); chk("R13 group1 status", d, 64'h8000_0000);
    wr1(0, ad(2, 8'h1C), 64'h8000_0000, 0);
    chk("R3 group1 clear drops irq", 64'(irq[2]), 0);
  endtask

  task automatic t_collide();
    logic [63:0] d; logic r;
    wr1(0, ad(3, 8'h08), 64'h10, 0);
    wr2(ad(3, 8'h08), 64'h1, ad(3, 8'h0C), 64'h11, 0);
    rd1(0, ad(3, 8'h00), 0, d, r); chk("R4 set wins over same-cycle clear", d, 64'h1);
  endtask

  task automatic t_merge();
    logic [63:0] d; logic r;
    wr2(ad(0, 8'h08), 64'h100, ad(0, 8'h08), 64'h200, 0);
    rd1(1, ad(0, 8'h00), 0, d, r); chk("R11 same-cycle posts merge", d, 64'h300);
    wr2(ad(0, 8'h04), 64'hAAAA, ad(0, 8'h04), 64'h5555, 0);
    rd1(0, ad(0, 8'h04), 0, d, r); chk("R11 higher port wins enable", d, 64'h5555);
    chk("R5 irq core0 from bit 8", 64'(irq[0]), 1);
    wr2(ad(0, 8'h38), 64'hAAAA_0000_AAAA_0000, ad(0, 8'h38), 64'hBBBB_0000_BBBB_0000, 1);
    rd1(0, ad(0, 8'h38), 1, d, r); chk("R11 higher port wins mailbox", d, 64'hBBBB_0000_BBBB_0000);
  endtask

  task automatic t_mbox();
    logic [63:0] d; logic r;
    for (int w = 0; w < 4; w++) wr1(w % 2, ad(1, 8'h20 + 8*w), mword(1, w), 1);
    for (int w = 0; w < 4; w++) begin
      rd1(0, ad(1, 8'h20 + 8*w), 1, d, r);
      chk($sformatf("R7 mailbox word %0d", w), d, mword(1, w));
    end
    rd1(1, ad(2, 8'h20), 1, d, r); chk("R9 other core mailbox untouched", d, 0);
  endtask

  task automatic t_half();
    logic [63:0] d; logic r;
    logic [63:0] w0;
    w0 = mword(1, 0);
    wr1(0, ad(1, 8'h24), 64'h0000_0000_DEAD_BEEF, 0);
    rd1(0, ad(1, 8'h20), 1, d, r); chk("R8 high half write", d, {32'hDEAD_BEEF, w0[31:0]});
    rd1(1, ad(1, 8'h20), 0, d, r); chk("R8 low half read", d, {32'h0, w0[31:0]});
    wr1(1, ad(1, 8'h20), 64'h0, 0);
    rd1(0, ad(1, 8'h24), 0, d, r); chk("R8 high half kept after low write", d, 64'hDEAD_BEEF);
    rd1(0, ad(1, 8'h20), 1, d, r); chk("R8 low half cleared", d, 64'hDEAD_BEEF_0000_0000);
  endtask

  task automatic t_ignored();
    logic [63:0] d; logic r;
    wr1(0, ad(0, 8'h00), 64'hFFFF_FFFF, 0);
    rd1(0, ad(0, 8'h00), 0, d, r); chk("R12 status not writable", d, 64'h300);
    wr1(0, ad(0, 8'h40), 64'h1234_5678, 0);
    rd1(0, ad(0, 8'h40), 0, d, r); chk("R12 unmapped reads zero", d, 0);
    wr1(1, ad(0, 8'h09), 64'h1, 0);
    wr1(1, ad(0, 8'h08), 64'hF0, 1);
    rd1(0, ad(0, 8'h00), 0, d, r); chk("R12 misaligned and 64-bit reg writes ignored", d, 64'h300);
    wr1(0, ad(1, 8'h2C), 64'hFFFF_FFFF_FFFF_FFFF, 1);
    rd1(0, ad(1, 8'h28), 1, d, r); chk("R12 64-bit at bit2 ignored", d, mword(1, 1));
  endtask

  task automatic t_ready();
    logic [63:0] d; logic r;
    rd1(1, ad(1, 8'h30), 1, d, r);
    chk("R10 ready with read data", 64'(r), 1);
    chk("R10 read data valid", d, mword(1, 2));
    @(negedge clk);
    chk("R10 ready low when idle", 64'(rdy), 0);
  endtask

  initial begin
    idle_all();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_set();
    t_clear_irq();
    t_group1();
    t_collide();
    t_merge();
    t_mbox();
    t_half();
    t_ignored();
    t_ready();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule